// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Delayed Deselect

This block is a small synchronous static memory with a two-stage pipeline. Every address, data and control input is captured on the rising clock edge. A captured access goes to the storage in the next cycle. Read data then leaves through an output register. A two-bit burst counter generates the follow-on addresses, so a host can start an access with one of two address strobes and then step through four words by pulling the advance input low.

Writes can update any subset of the byte lanes. A global write input updates every lane at once. Output drive is gated by an active-low output enable, and that gate acts without waiting for a clock edge. When the block is deselected after a read, one extra register keeps the output driven for one more cycle. Several of these memories can therefore share a read bus and be accessed back to back with no wait state between them. The burst order is linear by default; the parameter `LINEAR` set to 0 selects an XOR (interleaved) order.

Top module: `psram_dcd`

## Requirements
- R1: A synchronous active-high reset clears the pipeline: after reset `rvalid` is 0 and `rdata` is 0 until a read is issued.
- R2: A read whose inputs are sampled at rising edge E loads the output register at edge E+1. Its word is on `rdata`, with `rvalid` high, from E+1 until the next edge (provided `oe_n` is low).
- R3: An access starts only at an edge where `strb_cpu_n` or `strb_ctl_n` is low. If the chip is not selected at that edge (select is `ce_hi`=1 and `ce_lo_n`=0), the block goes inactive and performs no read or write. While no strobe is low, the `addr` input is ignored.
- R4: During a write, byte lane i (bits 8i+7..8i) is written when bit i of `bwe_n` is 0. Lanes whose bit is 1 keep their contents.
- R5: When `gw_n` is 0 during a write, all byte lanes are written, whatever `bwe_n` holds.
- R6: The burst changes only the two low address bits. With the default linear order, the n-th address after a start at a is (a+n) mod 4 in those bits. A cycle without a strobe steps the counter when `adv_n` is 0 and repeats the same address when `adv_n` is 1.
- R7: After the last read, the output stays driven for one extra cycle and holds the same word. It turns off in the cycle after that.
- R8: While `oe_n` is 1, `rvalid` is 0 and `rdata` is 0. A change on `oe_n` takes effect without a clock edge.
- R9: A read of an address in the cycle right after a write to that address returns the newly written data.
- R10: A start taken with `strb_cpu_n` low is always a read, and the write controls are ignored, even if `strb_ctl_n` is also low. A start taken with only `strb_ctl_n` low writes if `gw_n` is 0 or any `bwe_n` bit is 0. While the block is active, a cycle without a strobe writes on the same rule.
- R11: A write cycle does not drive the output. Apart from the extra cycle after a read, `rvalid` stays 0 in the output cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, taken only at a start |
| ce_hi | input | 1 | Active-high chip select |
| ce_lo_n | input | 1 | Active-low chip select |
| strb_cpu_n | input | 1 | Active-low start strobe, always a read |
| strb_ctl_n | input | 1 | Active-low start strobe, read or write |
| adv_n | input | 1 | Active-low burst advance |
| bwe_n | input | NBYTES | Active-low per-lane write enables |
| gw_n | input | 1 | Active-low write of all lanes |
| wdata | input | NBYTES*8 | Write data |
| oe_n | input | 1 | Active-low asynchronous output enable |
| rdata | output | NBYTES*8 | Read data, zero when not driven |
| rvalid | output | 1 | Output driven with valid data |

## Verification
The assertions assume that `oe_n` changes only between clock edges. They also assume that reset is not raised in the middle of a read whose two output cycles are being checked. The stimulus moves every input one time unit after a falling edge and keeps reset low once the tests begin. The storage has no reset, so the stimulus writes every address before it reads any. Each burst is ended with a deselect strobe, which keeps the active state known at every step.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int BYTE_BITS  = 8;
    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/psram_burst.sv
module psram_burst
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter bit LINEAR = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_next
);

    logic [ADDR_W-1:0]     base_q, base_d;
    logic [BURST_BITS-1:0] cnt_q, cnt_d, off;

    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        if (load) begin
            base_d = addr_in;
            cnt_d  = '0;
        end else if (step) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    generate
        if (LINEAR) begin : g_linear
            assign off = base_d[BURST_BITS-1:0] + cnt_d;
        end else begin : g_xor
            assign off = base_d[BURST_BITS-1:0] ^ cnt_d;
        end
    endgenerate

    assign addr_next = {base_d[ADDR_W-1:BURST_BITS], off};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

endmodule

// File: rtl/psram_store.sv
module psram_store
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NBYTES-1:0]           wmask,
    input  logic [NBYTES*BYTE_BITS-1:0] wdata,
    output logic [NBYTES*BYTE_BITS-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            logic [BYTE_BITS-1:0] lane [DEPTH];

            always_ff @(posedge clk) begin
                if (we && wmask[b]) begin
                    lane[addr] <= wdata[b*BYTE_BITS +: BYTE_BITS];
                end
            end

            assign rdata[b*BYTE_BITS +: BYTE_BITS] = lane[addr];
        end
    endgenerate

endmodule

// File: rtl/psram_outpipe.sv
module psram_outpipe #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] word,
    input  logic          oe_n,
    output logic [DW-1:0] dq,
    output logic          dv
);

    logic [DW-1:0] data_q;
    logic          rd_q;
    logic          hold_q;
    logic          drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rd_q   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            rd_q   <= load;
            hold_q <= rd_q;
            if (load) begin
                data_q <= word;
            end
        end
    end

    assign drive = (rd_q | hold_q) & ~oe_n;
    assign dq    = drive ? data_q : '0;
    assign dv    = drive;

endmodule

// File: rtl/psram_dcd.sv
module psram_dcd
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter bit LINEAR = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        ce_hi,
    input  logic                        ce_lo_n,
    input  logic                        strb_cpu_n,
    input  logic                        strb_ctl_n,
    input  logic                        adv_n,
    input  logic [NBYTES-1:0]           bwe_n,
    input  logic                        gw_n,
    input  logic [NBYTES*BYTE_BITS-1:0] wdata,
    input  logic                        oe_n,
    output logic [NBYTES*BYTE_BITS-1:0] rdata,
    output logic                        rvalid
);

    localparam int DW = NBYTES * BYTE_BITS;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic [NBYTES-1:0] mask;
    } cmd_t;

    cmd_t              cmd_q, cmd_d;
    logic              active_q, active_d;
    logic              chip_sel, start, wr_req, load, step;
    logic [ADDR_W-1:0] acc_addr;
    logic [DW-1:0]     store_word;

    assign chip_sel = ce_hi & ~ce_lo_n;
    assign start    = ~strb_cpu_n | ~strb_ctl_n;
    assign wr_req   = ~gw_n | ~(&bwe_n);
    assign load     = start & chip_sel;
    assign step     = ~start & active_q & ~adv_n;
    assign active_d = start ? chip_sel : active_q;

    psram_burst #(.ADDR_W(ADDR_W), .LINEAR(LINEAR)) burst_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .addr_in   (addr),
        .addr_next (acc_addr)
    );

    always_comb begin
        cmd_d.addr = acc_addr;
        cmd_d.data = wdata;
        cmd_d.mask = gw_n ? ~bwe_n : '1;
        if (!active_d) begin
            cmd_d.op = OP_IDLE;
        end else if (start && !strb_cpu_n) begin
            cmd_d.op = OP_READ;
        end else begin
            cmd_d.op = wr_req ? OP_WRITE : OP_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cmd_q    <= '{op: OP_IDLE, addr: '0, data: '0, mask: '0};
        end else begin
            active_q <= active_d;
            cmd_q    <= cmd_d;
        end
    end

    psram_store #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) store_i (
        .clk   (clk),
        .we    (cmd_q.op == OP_WRITE),
        .addr  (cmd_q.addr),
        .wmask (cmd_q.mask),
        .wdata (cmd_q.data),
        .rdata (store_word)
    );

    psram_outpipe #(.DW(DW)) outpipe_i (
        .clk  (clk),
        .rst  (rst),
        .load (cmd_q.op == OP_READ),
        .word (store_word),
        .oe_n (oe_n),
        .dq   (rdata),
        .dv   (rvalid)
    );

endmodule

// File: rtl/psram_dcd_chk.sv
module psram_dcd_chk
    import psram_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_hi,
    input logic              ce_lo_n,
    input logic              strb_cpu_n,
    input logic              strb_ctl_n,
    input logic              gw_n,
    input logic              oe_n,
    input logic              rvalid,
    input op_e               cmd_op,
    input logic [NBYTES-1:0] cmd_mask
);

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> !rvalid);

    assert_deselect_no_access_R3: assert property (@(posedge clk) disable iff (rst)
        ((!strb_cpu_n || !strb_ctl_n) && !(ce_hi && !ce_lo_n)) |=> (cmd_op == OP_IDLE));

    assert_global_write_all_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        (strb_cpu_n && !strb_ctl_n && ce_hi && !ce_lo_n && !gw_n)
        |=> (cmd_op == OP_WRITE && cmd_mask == '1));

    assert_cpu_start_reads_R10: assert property (@(posedge clk) disable iff (rst)
        (!strb_cpu_n && ce_hi && !ce_lo_n) |=> (cmd_op == OP_READ));

    assert_drive_two_cycles_R7: assert property (@(posedge clk) disable iff (rst)
        (!strb_cpu_n && ce_hi && !ce_lo_n) |=> ##1 (rvalid || oe_n) ##1 (rvalid || oe_n));

    assert_oe_gates_output_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rvalid);

endmodule

bind psram_dcd psram_dcd_chk #(.NBYTES(NBYTES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ce_hi      (ce_hi),
    .ce_lo_n    (ce_lo_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .gw_n       (gw_n),
    .oe_n       (oe_n),
    .rvalid     (rvalid),
    .cmd_op     (cmd_q.op),
    .cmd_mask   (cmd_q.mask)
);

// File: tb/psram_dcd_tb_top.sv
`timescale 1ns/100ps
module psram_dcd_tb_top;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ce_hi = 1'b0, ce_lo_n = 1'b1;
    logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
    logic [NB-1:0] bwe_n = '1;
    logic          gw_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    psram_dcd dut_i (
        .clk(clk), .rst(rst), .addr(addr), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .bwe_n(bwe_n), .gw_n(gw_n), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill(int i);
        logic [7:0] b = 8'(i);
        return {8'hA5, b, ~b, b + 8'd3};
    endfunction

    // behavioural reference model
    logic [DW-1:0] mm [1 << AW];
    bit            m_act, m_rd, m_hold;
    logic [DW-1:0] m_dq;
    int            m_base, m_cnt, p_op, p_addr;
    logic [DW-1:0] p_data;
    logic [NB-1:0] p_mask;

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_rd = 0; m_hold = 0; m_dq = '0;
            m_base = 0; m_cnt = 0; p_op = 0;
        end else begin
            bit sel, st, wr;
            m_hold = m_rd;
            m_rd   = (p_op == 1);
            if (p_op == 1) m_dq = mm[p_addr];
            else if (p_op == 2)
                for (int b = 0; b < NB; b++)
                    if (p_mask[b]) mm[p_addr][b*8 +: 8] = p_data[b*8 +: 8];
            sel = ce_hi && !ce_lo_n;
            st  = !strb_cpu_n || !strb_ctl_n;
            wr  = !gw_n || (bwe_n != '1);
            if (st) begin
                m_act = sel;
                if (sel) begin m_base = int'(addr); m_cnt = 0; end
            end else if (m_act && !adv_n) begin
                m_cnt = (m_cnt + 1) % 4;
            end
            if (!m_act)                  p_op = 0;
            else if (st && !strb_cpu_n)  p_op = 1;
            else                         p_op = wr ? 2 : 1;
            p_addr = (m_base / 4) * 4 + ((m_base + m_cnt) % 4);
            p_data = wdata;
            p_mask = gw_n ? ~bwe_n : '1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit ev;
            ev = (m_rd || m_hold) && !oe_n;
            chk("R2 model valid", DW'(rvalid), DW'(ev));
            chk("R2 model data", rdata, ev ? m_dq : '0);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put(bit cpu, bit ctl, bit sel, int a, bit adv,
                       logic [NB-1:0] bw, bit g, logic [DW-1:0] d);
        #1;
        strb_cpu_n = ~cpu; strb_ctl_n = ~ctl;
        ce_hi = sel; ce_lo_n = ~sel;
        addr = AW'(a); adv_n = ~adv; bwe_n = bw; gw_n = g; wdata = d;
    endtask

    task automatic rd_cpu(int a);  put(1, 0, 1, a, 0, '1, 1, '0); endtask
    task automatic desel();        put(0, 1, 0, 0, 0, '1, 1, '0); endtask
    task automatic advance();      put(0, 0, 1, 0, 1, '1, 1, '0); endtask
    task automatic stay();         put(0, 0, 1, 0, 0, '1, 1, '0); endtask

    initial begin
        #(8 * 50000);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] e;
        repeat (3) step();
        #1 rst = 1'b0;
        step();
        chk("R1 rvalid after reset", DW'(rvalid), '0);
        chk("R1 rdata after reset", rdata, '0);

        for (int i = 0; i < (1 << AW); i++) begin
            put(0, 1, 1, i, 0, '1, 0, fill(i));
            step();
        end
        desel(); step(); step(); step();

        // single read, delayed turn-off, asynchronous output enable
        rd_cpu(5); step(); desel(); step();
        chk("R2 read valid", DW'(rvalid), 1);
        chk("R2 read data", rdata, fill(5));
        #0.5 oe_n = 1'b1;
        #0.5 chk("R8 oe high valid", DW'(rvalid), 0);
        chk("R8 oe high data", rdata, '0);
        oe_n = 1'b0;
        #0.5 chk("R8 oe low data", rdata, fill(5));
        step();
        chk("R7 extra cycle valid", DW'(rvalid), 1);
        chk("R7 extra cycle data", rdata, fill(5));
        step();
        chk("R7 off after extra cycle", DW'(rvalid), 0);
        step();

        // linear burst from 6 with a controller-strobe read
        put(0, 1, 1, 6, 0, '1, 1, '0); step();
        advance(); step(); chk("R6 burst word0", rdata, fill(6));
        advance(); step(); chk("R6 burst word1", rdata, fill(7));
        advance(); step(); chk("R6 burst word2 wrap", rdata, fill(4));
        desel();   step(); chk("R6 burst word3", rdata, fill(5));
        step(); step();

        // advance high repeats the address
        put(0, 1, 1, 9, 0, '1, 1, '0); step();
        stay();    step(); chk("R6 hold first", rdata, fill(9));
        advance(); step(); chk("R6 hold repeat", rdata, fill(9));
        desel();   step(); chk("R6 hold then step", rdata, fill(10));
        step(); step();

        // address change without strobe is ignored
        rd_cpu(32); step();
        put(0, 0, 1, 40, 0, '1, 1, '0); step(); chk("R3 strobe read", rdata, fill(32));
        desel(); step(); chk("R3 addr ignored without strobe", rdata, fill(32));
        step(); step();

        // write attempt while deselected
        put(0, 1, 0, 33, 0, '0, 0, '0); step(); desel(); step();
        rd_cpu(33); step(); desel(); step();
        chk("R3 deselected write dropped", rdata, fill(33));
        step(); step();

        // byte write then immediate read
        put(0, 1, 1, 12, 0, 4'b1010, 1, 32'h11223344); step();
        rd_cpu(12); step();
        chk("R11 no drive for write", DW'(rvalid), 0);
        desel(); step();
        e = (fill(12) & 32'hFF00FF00) | (32'h11223344 & 32'h00FF00FF);
        chk("R4 byte lanes", rdata, e);
        chk("R9 read after write", rdata, e);
        step(); step();

        // global write overrides lane enables
        put(0, 1, 1, 13, 0, 4'b0111, 0, 32'hDEADBEEF); step();
        rd_cpu(13); step(); desel(); step();
        chk("R5 global write", rdata, 32'hDEADBEEF);
        step(); step();

        // processor-strobe start ignores write controls
        put(1, 0, 1, 20, 0, 4'h0, 0, '0); step(); desel(); step();
        chk("R10 cpu start reads", rdata, fill(20));
        step(); step();
        rd_cpu(20); step(); desel(); step();
        chk("R10 cpu start wrote nothing", rdata, fill(20));
        step(); step();
        put(1, 1, 1, 21, 0, '1, 0, '0); step(); desel(); step();
        chk("R10 both strobes read", rdata, fill(21));
        step(); step();
        rd_cpu(22); step();
        put(0, 0, 1, 0, 0, '1, 0, 32'h0BADF00D); step();
        desel(); step(); step(); step();
        rd_cpu(22); step(); desel(); step();
        chk("R10 follow-on write", rdata, 32'h0BADF00D);
        step(); step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule